// File: doc/BRIEF.md
# Branch and Constant-Prefix Sequencer

This unit owns the program counter and the one-bit prefix flag of a 16-bit-instruction processor. Each cycle it receives the instruction at the current address. It also receives the four condition flags, the newest short-term value (the top of the result queue) and one short-term value selected by the surrounding datapath. From these it works out where the next instruction is. For the instruction classes it owns, it also produces the value to push into the result queue.

Wide constants and long branch offsets are built from 13-bit prefix instructions. A prefix sets the flag. The next instruction then ORs the newest queued value, shifted left by its own field width, into its own field. Any instruction that is not a prefix clears the flag again.

Branch offsets are turned into even byte offsets. An odd field value means a backwards jump.

Top module: `flow_seq`

## Requirements
- R1: A synchronous `rst` sets `pc` to 0 and `q` to 0 on the next rising edge.
- R2: A prefix instruction (`insn[15:13]` = 110) raises `push`. Its `result` is the zero-extended `insn[12:0]`, ORed with `s0_val << 13` when `q` is 1. After the edge, `q` is 1.
- R3: Every instruction that is not a prefix leaves `q` at 0 after the edge.
- R4: A short constant (`insn[15:11]` = 11110) raises `push`. Its `result` is the zero-extended `insn[10:0]`, ORed with `s0_val << 11` when `q` is 1.
- R5: A direct jump or call (`insn[15:12]` = 1110) pushes `pc + 2`. It sets `next_pc` = `pc + even(v)`, where v is the zero-extended `insn[10:0]` ORed with `s0_val << 11` when `q` is 1.
- R6: even(v) is v when v is even, and the bitwise inverse of v (that is, -(v+1)) when v is odd.
- R7: A conditional branch (`insn[15:11]` = 11111, code c = `insn[10:8]` not 111) tests one condition. The conditions are Z for c=0, C for c=1, N for c=2 and V for c=3. For c=4 it is C and not Z, for c=5 it is N equal to V, and for c=6 it is N equal to V and not Z. `insn[7]` = 1 inverts the test. The flags are `flags[3:0]` = {N, Z, C, V}.
- R8: A taken branch pushes all ones and sets `next_pc` = `pc + even(v)`, where v is the zero-extended `insn[6:0]` ORed with `s0_val << 7` when `q` is 1. A branch that is not taken pushes 0 and sets `next_pc` = `pc + 2`.
- R9: A register jump (`insn[15:5]` = 11111111000, 11111111001 or 11111111010) pushes `pc + 2`. It sets `next_pc` to `sreg_val` with bit 0 cleared.
- R10: All other words (bit 15 = 0, prefixes 100 and 101, and `insn[15:8]` = 0xFF with `insn[7:5]` from 011 to 111) give `push` = 0, `result` = 0 and `next_pc` = `pc + 2`.
- R11: `pc` takes `next_pc` at every edge out of reset, and `pc` is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn | input | 16 | Instruction at the current address |
| flags | input | 4 | Condition flags {N, Z, C, V} |
| s0_val | input | 64 | Newest short-term value |
| sreg_val | input | 64 | Short-term value named by the register-jump field |
| pc | output | 64 | Address of the current instruction |
| next_pc | output | 64 | Address of the following instruction |
| result | output | 64 | Value to push into the short-term queue |
| push | output | 1 | `result` is valid for this instruction |
| q | output | 1 | Prefix flag as seen by the current instruction |

## Verification
The hardest case to reach from the ports is an instruction that consumes a prefix. The flag is internal and only rises when the word before it was a prefix, so both the order of instructions and the `s0_val` value must be set up. The stimulus table therefore walks a fixed sequence without resetting. A prefix is placed directly before a short constant, a jump and a branch, and `s0_val` is chosen so that the widened field has an odd value. This makes the prefix feed the backward-offset mapping.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int ILEN = 16;

    typedef enum logic [2:0] {
        K_OTHER  = 3'd0,
        K_PREFIX = 3'd1,
        K_CONST  = 3'd2,
        K_DJUMP  = 3'd3,
        K_BRANCH = 3'd4,
        K_RJUMP  = 3'd5
    } kind_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output kind_e           kind,
    output logic [2:0]      cc,
    output logic            inv
);
    always_comb begin
        kind = K_OTHER;
        if (insn[15:13] == 3'b110)
            kind = K_PREFIX;
        else if (insn[15:12] == 4'b1110)
            kind = K_DJUMP;
        else if (insn[15:11] == 5'b11110)
            kind = K_CONST;
        else if (insn[15:11] == 5'b11111) begin
            if (insn[10:8] != 3'b111)
                kind = K_BRANCH;
            else if (!insn[7] && insn[6:5] != 2'b11)
                kind = K_RJUMP;
        end
    end

    assign cc  = insn[10:8];
    assign inv = insn[7];
endmodule

// File: rtl/seq_cond.sv
module seq_cond (
    input  logic [2:0] cc,
    input  logic       inv,
    input  logic [3:0] flags,
    output logic       pass
);
    logic fn, fz, fc, fv, raw;

    assign {fn, fz, fc, fv} = flags;

    always_comb begin
        case (cc)
            3'd0:    raw = fz;
            3'd1:    raw = fc;
            3'd2:    raw = fn;
            3'd3:    raw = fv;
            3'd4:    raw = fc & ~fz;
            3'd5:    raw = (fn == fv);
            3'd6:    raw = (fn == fv) & ~fz;
            default: raw = 1'b0;
        endcase
        pass = raw ^ inv;
    end
endmodule

// File: rtl/seq_widen.sv
module seq_widen #(
    parameter int XLEN     = 64,
    parameter int FW       = 11,
    parameter bit EVEN_MAP = 1'b0
) (
    input  logic [FW-1:0]   field,
    input  logic            q,
    input  logic [XLEN-1:0] s0,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] wide;

    assign wide = XLEN'(field) | (q ? (s0 << FW) : '0);

    generate
        if (EVEN_MAP) begin : g_even
            assign value = wide[0] ? ~wide : wide;
        end else begin : g_plain
            assign value = wide;
        end
    endgenerate
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import seq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PFX_W  = 13,
    parameter int LONG_W = 11,
    parameter int BR_W   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     insn,
    input  logic [3:0]      flags,
    input  logic [XLEN-1:0] s0_val,
    input  logic [XLEN-1:0] sreg_val,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] result,
    output logic            push,
    output logic            q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(2);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            q;
    } st_t;

    st_t st_q, st_d;

    kind_e           kind;
    logic [2:0]      cc;
    logic            inv;
    logic            pass;
    logic [XLEN-1:0] pfx_val, imm_val, jmp_off, br_off;
    logic [XLEN-1:0] here, seq_pc;

    seq_decode u_dec (.insn(insn), .kind(kind), .cc(cc), .inv(inv));

    seq_cond u_cond (.cc(cc), .inv(inv), .flags(flags), .pass(pass));

    seq_widen #(.XLEN(XLEN), .FW(PFX_W), .EVEN_MAP(1'b0)) u_pfx (
        .field(insn[PFX_W-1:0]), .q(st_q.q), .s0(s0_val), .value(pfx_val));

    seq_widen #(.XLEN(XLEN), .FW(LONG_W), .EVEN_MAP(1'b0)) u_imm (
        .field(insn[LONG_W-1:0]), .q(st_q.q), .s0(s0_val), .value(imm_val));

    seq_widen #(.XLEN(XLEN), .FW(LONG_W), .EVEN_MAP(1'b1)) u_jmp (
        .field(insn[LONG_W-1:0]), .q(st_q.q), .s0(s0_val), .value(jmp_off));

    seq_widen #(.XLEN(XLEN), .FW(BR_W), .EVEN_MAP(1'b1)) u_br (
        .field(insn[BR_W-1:0]), .q(st_q.q), .s0(s0_val), .value(br_off));

    assign here   = st_q.pc;
    assign seq_pc = here + STEP;

    always_comb begin
        st_d    = st_q;
        st_d.q  = 1'b0;
        st_d.pc = seq_pc;
        result  = '0;
        push    = 1'b0;
        case (kind)
            K_PREFIX: begin
                result = pfx_val;
                push   = 1'b1;
                st_d.q = 1'b1;
            end
            K_CONST: begin
                result = imm_val;
                push   = 1'b1;
            end
            K_DJUMP: begin
                result  = seq_pc;
                push    = 1'b1;
                st_d.pc = here + jmp_off;
            end
            K_BRANCH: begin
                push = 1'b1;
                if (pass) begin
                    result  = '1;
                    st_d.pc = here + br_off;
                end
            end
            K_RJUMP: begin
                result  = seq_pc;
                push    = 1'b1;
                st_d.pc = sreg_val & ~XLEN'(1);
            end
            default: ;
        endcase
        if (rst) begin
            st_d.pc = '0;
            st_d.q  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc      = st_q.pc;
    assign q       = st_q.q;
    assign next_pc = st_d.pc;

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0 && !q));

    // R2: a prefix leaves the flag raised
    a_r2_prefix_sets_q: assert property (@(posedge clk) disable iff (rst)
        (insn[15:13] == 3'b110) |=> q);

    // R3: anything else drops the flag
    a_r3_other_clears_q: assert property (@(posedge clk) disable iff (rst)
        (insn[15:13] != 3'b110) |=> !q);

    // R8: branch result is all zeros or all ones; not taken falls through
    a_r8_branch_result: assert property (@(posedge clk) disable iff (rst)
        (insn[15:11] == 5'b11111 && insn[10:8] != 3'b111) |->
            (push && (result == '0 || result == '1)));
    a_r8_not_taken_seq: assert property (@(posedge clk) disable iff (rst)
        (insn[15:11] == 5'b11111 && insn[10:8] != 3'b111 && result == '0) |->
            (next_pc == pc + STEP));

    // R10: data-path words just step the address
    a_r10_dataflow_step: assert property (@(posedge clk) disable iff (rst)
        (!insn[15]) |=> (pc == $past(pc) + STEP));

    // R11: address stays even
    a_r11_pc_even: assert property (@(posedge clk) disable iff (rst)
        !pc[0]);
endmodule

// File: tb/sim_flow_seq.sv
module sim_flow_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] insn;
    logic [3:0]  flags;
    logic [63:0] s0_val, sreg_val;
    logic [63:0] pc, next_pc, result;
    logic        push, q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flow_seq u0 (
        .clk(clk), .rst(rst), .insn(insn), .flags(flags),
        .s0_val(s0_val), .sreg_val(sreg_val),
        .pc(pc), .next_pc(next_pc), .result(result), .push(push), .q(q)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic [3:0]  fl;
        logic [63:0] s0;
        logic [63:0] res;
        logic        rel;
        logic        psh;
        logic        qv;
        logic [63:0] off;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    // fields: insn, flags{N,Z,C,V}, s0, result, result relative to pc, push, q seen, pc offset, req
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b0, 1'b0, 64'd2, 8'd10},  // R10 data-path word
        '{16'hC123, 4'b0000, 64'hFFFF, 64'h123,      1'b0, 1'b1, 1'b0, 64'd2, 8'd2},   // R2 prefix, no chain
        '{16'hF005, 4'b0000, 64'h123,  64'h91805,    1'b0, 1'b1, 1'b1, 64'd2, 8'd4},   // R4 widened constant
        '{16'hF7FF, 4'b0000, 64'h55,   64'h7FF,      1'b0, 1'b1, 1'b0, 64'd2, 8'd4},   // R4 plain constant
        '{16'hE010, 4'b0000, 64'h0,    64'd2,        1'b1, 1'b1, 1'b0, 64'd16, 8'd5},  // R5 forward jump
        '{16'hE803, 4'b0000, 64'h0,    64'd2,        1'b1, 1'b1, 1'b0, -64'sd4, 8'd6}, // R6 odd -> backward call
        '{16'hC001, 4'b0000, 64'h0,    64'h1,        1'b0, 1'b1, 1'b0, 64'd2, 8'd2},   // R2
        '{16'hE001, 4'b0000, 64'h1,    64'd2,        1'b1, 1'b1, 1'b1, -64'sd2050, 8'd5}, // R5 chained jump
        '{16'hF808, 4'b0100, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd8, 8'd7},   // R7 Z taken
        '{16'hF808, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b1, 1'b0, 64'd2, 8'd8},   // R8 not taken
        '{16'hF888, 4'b0000, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd8, 8'd7},   // R7 inverted
        '{16'hFC10, 4'b0010, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd16, 8'd7},  // R7 C&!Z
        '{16'hFC10, 4'b0110, 64'h0,    64'h0,        1'b0, 1'b1, 1'b0, 64'd2, 8'd7},   // R7 C&!Z fails
        '{16'hFD04, 4'b1001, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd4, 8'd7},   // R7 N==V
        '{16'hFD04, 4'b1000, 64'h0,    64'h0,        1'b0, 1'b1, 1'b0, 64'd2, 8'd7},   // R7 N!=V
        '{16'hFE06, 4'b0000, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd6, 8'd7},   // R7 gt
        '{16'hFE06, 4'b0100, 64'h0,    64'h0,        1'b0, 1'b1, 1'b0, 64'd2, 8'd7},   // R7 gt with Z
        '{16'hF902, 4'b0010, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd2, 8'd7},   // R7 C
        '{16'hFA0C, 4'b1000, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd12, 8'd7},  // R7 N
        '{16'hFB0E, 4'b0001, 64'h0,    ONES,         1'b0, 1'b1, 1'b0, 64'd14, 8'd7},  // R7 V
        '{16'hDFFF, 4'b0000, 64'h0,    64'h1FFF,     1'b0, 1'b1, 1'b0, 64'd2, 8'd2},   // R2
        '{16'hC000, 4'b0000, 64'h1FFF, 64'h3FFE000,  1'b0, 1'b1, 1'b1, 64'd2, 8'd2},   // R2 chained prefix
        '{16'hF803, 4'b0100, 64'h2,    ONES,         1'b0, 1'b1, 1'b1, -64'sd260, 8'd8}, // R8 chained backward
        '{16'h7FFF, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b0, 1'b0, 64'd2, 8'd3},   // R3 q dropped
        '{16'hFFE0, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b0, 1'b0, 64'd2, 8'd10},  // R10
        '{16'h8000, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b0, 1'b0, 64'd2, 8'd10},  // R10
        '{16'hFF80, 4'b0000, 64'h0,    64'h0,        1'b0, 1'b0, 1'b0, 64'd2, 8'd10}   // R10
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] exp_pc;
        logic [63:0] exp_res;
        string tag;
        rst = 1'b1; insn = 16'h0000; flags = 4'b0; s0_val = '0; sreg_val = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pc == 64'd0, "R1 pc", pc, 64'd0);
        chk(q == 1'b0, "R1 q", {63'd0, q}, 64'd0);
        rst = 1'b0;
        exp_pc = 64'd0;

        for (int i = 0; i < NV; i++) begin
            insn = VECS[i].ins; flags = VECS[i].fl; s0_val = VECS[i].s0;
            sreg_val = '0;
            #5;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            exp_res = VECS[i].rel ? exp_pc + VECS[i].res : VECS[i].res;
            chk(pc == exp_pc, {tag, " R11 pc"}, pc, exp_pc);
            chk(q == VECS[i].qv, {tag, " q"}, {63'd0, q}, {63'd0, VECS[i].qv});
            chk(push == VECS[i].psh, {tag, " push"}, {63'd0, push}, {63'd0, VECS[i].psh});
            chk(result == exp_res, {tag, " result"}, result, exp_res);
            chk(next_pc == exp_pc + VECS[i].off, {tag, " next_pc"}, next_pc,
                exp_pc + VECS[i].off);
            exp_pc = exp_pc + VECS[i].off;
            @(negedge clk);
        end

        // R9 register jump with odd source, then R11 pc loads it
        insn = 16'hFF03; sreg_val = 64'h1234_5679; #5;
        chk(push && result == pc + 64'd2, "R9 jump result", result, pc + 64'd2);
        chk(next_pc == 64'h1234_5678, "R9 jump target", next_pc, 64'h1234_5678);
        @(negedge clk);
        chk(pc == 64'h1234_5678, "R11 pc loaded", pc, 64'h1234_5678);
        insn = 16'hFF20; sreg_val = 64'h40; #5;
        chk(next_pc == 64'h40 && push, "R9 call target", next_pc, 64'h40);
        @(negedge clk);
        insn = 16'hFF5F; sreg_val = 64'h101; #5;
        chk(next_pc == 64'h100 && result == 64'h42, "R9 return", next_pc, 64'h100);
        @(negedge clk);

        // R1 reset in the middle of a prefix chain
        insn = 16'hC0AA; #5;
        @(negedge clk);
        chk(q == 1'b1, "R2 q raised", {63'd0, q}, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(pc == 64'd0 && q == 1'b0, "R1 mid reset", pc, 64'd0);
        rst = 1'b0;
        insn = 16'hF001; s0_val = 64'hF; #5;
        chk(result == 64'd1, "R1 q cleared by reset", result, 64'd1);
        @(negedge clk);
        finish_run();
    end
endmodule